// File: doc/BRIEF.md
# Boot Flash Protected Range Checker

This block guards the address space of a boot flash. It keeps a small table of programmable protected windows. Each window has a start address, a length count, a unit selector and two protect enables, one for reads and one for writes. Every read or write request that reaches the block is tested against all windows at once. One cycle later the block answers with allow or deny. A denied answer also reports the kind of violation and the index of the window that refused the access.

Boot code loads the windows through a simple write port, one whole window per write, and then seals the table. Sealing is sticky: only reset opens the table again. While the table is sealed, every write is dropped and an error pulse is raised.

The seal is kept by a two-state machine:
- State `LK_OPEN` is left by the transition OPEN->SEALED when `cfg_lock` is high on a clock edge.
- State `LK_SEALED` is held by the transition SEALED->SEALED on every edge.
- Reset is the only way back to `LK_OPEN`.

Top module: `flash_guard`

## Requirements
- R1: After reset the table is open and every window has count 0. In that state every request is allowed, and `rsp_valid`, `cfg_err` and `locked` are 0.
- R2: With the unit bit 0, a window's length is its count times 0x1000 bytes (count 0xDF gives 0xDF000).
- R3: With the unit bit 1, a window's length is its count times 0x10000 bytes (count 0x39 gives 0x390000).
- R4: A window covers the half-open interval [start, start+length). The start address and start+length-1 are inside it. start-1 and start+length are outside it.
- R5: A read (`req_write`=0) is denied only by a covering window whose read-protect bit is set. A write (`req_write`=1) is denied only by a covering window whose write-protect bit is set. A denied read raises `rsp_rd_viol`, a denied write raises `rsp_wr_viol`, and the two are never high together.
- R6: A window with count 0 never covers any address, whatever its start address and protect bits.
- R7: The response is registered. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_deny` and the violation flags are 0 whenever `rsp_valid` is 0.
- R8: `rsp_idx` carries the lowest index among the windows that deny the request. A lower window that covers the address but does not deny it is skipped. `rsp_idx` is 0 when the request is allowed.
- R9: `cfg_lock` high while open moves the block to sealed. `locked` reads 1 from the next cycle until reset.
- R10: A write (`cfg_we`) while sealed changes no window. `cfg_err` is 1 for exactly one cycle, the cycle after that write.
- R11: A window write and `cfg_lock` in the same cycle while open both take effect. The window is written and the table is sealed.
- R12: A window write (`cfg_idx` selects window 0..N_ENT-1) applies to requests from the next cycle on. A request in the same cycle as the write is judged against the old table.
- R13: A window that extends past the top of the address space covers every address up to the top. It does not wrap around to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write one window |
| cfg_idx | input | IDX_W | Index of the window to write |
| cfg_base | input | ADDR_W | Window start address |
| cfg_cnt | input | CNT_W | Window length count |
| cfg_unit | input | 1 | Length unit: 0 = 4 KB, 1 = 64 KB |
| cfg_rp | input | 1 | Read-protect enable |
| cfg_wp | input | 1 | Write-protect enable |
| cfg_lock | input | 1 | Seal the table |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_deny | output | 1 | Request refused |
| rsp_rd_viol | output | 1 | Refused read |
| rsp_wr_viol | output | 1 | Refused write |
| rsp_idx | output | IDX_W | Lowest denying window |
| cfg_err | output | 1 | Write attempted while sealed |
| locked | output | 1 | Table sealed |

## Verification
Two things can happen in the same cycle: a table update (a window write, the seal, or both) and the check of a request. The bench provokes this by raising `cfg_we` and `req_valid` at the same edge. The new window is chosen so that it would change the verdict. The response must show the old table, and a repeat of the request one cycle later must show the new one. The same stimulus, with `cfg_lock` added, shows that the write lands before the seal and that the next write raises the error pulse.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_st_e;

    localparam int UNIT_SMALL_SHIFT = 12;
    localparam int UNIT_LARGE_SHIFT = 16;

endpackage

// File: rtl/fg_lock_fsm.sv
`timescale 1ns/1ps
module fg_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_lock,
    output logic wr_grant,
    output logic locked,
    output logic cfg_err
);
    import flash_guard_pkg::*;

    lock_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   state_d = cfg_lock ? LK_SEALED : LK_OPEN;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_we && (state_q == LK_SEALED);
    end

    assign wr_grant = cfg_we && (state_q == LK_OPEN);
    assign locked   = (state_q == LK_SEALED);

    // R9: sealing is sticky until reset
    p_seal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R10: an error pulse only ever appears in the sealed state
    p_err_when_sealed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> locked);

endmodule

// File: rtl/fg_entry.sv
`timescale 1ns/1ps
module fg_entry #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] d_base,
    input  logic [CNT_W-1:0]  d_cnt,
    input  logic              d_unit,
    input  logic              d_rp,
    input  logic              d_wp,
    input  logic              locked,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              q_write,
    output logic              covers,
    output logic              denies
);
    import flash_guard_pkg::*;

    localparam int SPAN_W = ADDR_W + 1;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              unit_q, rp_q, wp_q;
    logic [SPAN_W-1:0] cnt_ext, size, end_x;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            unit_q <= 1'b0;
            rp_q   <= 1'b0;
            wp_q   <= 1'b0;
        end else if (wr_en) begin
            base_q <= d_base;
            cnt_q  <= d_cnt;
            unit_q <= d_unit;
            rp_q   <= d_rp;
            wp_q   <= d_wp;
        end
    end

    always_comb begin
        cnt_ext = SPAN_W'(cnt_q);
        size    = unit_q ? (cnt_ext << UNIT_LARGE_SHIFT)
                         : (cnt_ext << UNIT_SMALL_SHIFT);
        end_x   = {1'b0, base_q} + size;
        covers  = (cnt_q != '0) && (q_addr >= base_q)
                  && ({1'b0, q_addr} < end_x);
        denies  = covers && (q_write ? wp_q : rp_q);
    end

    // R10: a sealed table holds every field
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({base_q, cnt_q, unit_q, rp_q, wp_q}));

    // R6: a zero count matches nothing
    p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !covers);

    // R5: a denial needs a covering window
    p_deny_needs_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        denies |-> covers);

endmodule

// File: rtl/fg_pick.sv
`timescale 1ns/1ps
module fg_pick #(
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_ENT-1:0] deny_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |deny_vec;
        idx = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (deny_vec[e]) idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard #(
    parameter  int ADDR_W = 32,
    parameter  int CNT_W  = 8,
    parameter  int N_ENT  = 4,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic              cfg_unit,
    input  logic              cfg_rp,
    input  logic              cfg_wp,
    input  logic              cfg_lock,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_deny,
    output logic              rsp_rd_viol,
    output logic              rsp_wr_viol,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic              cfg_err,
    output logic              locked
);
    logic             wr_grant;
    logic [N_ENT-1:0] cover_vec, deny_vec;
    logic             deny_any;
    logic [IDX_W-1:0] deny_idx;

    fg_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_lock (cfg_lock),
        .wr_grant (wr_grant),
        .locked   (locked),
        .cfg_err  (cfg_err)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        fg_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_grant && (cfg_idx == IDX_W'(g))),
            .d_base  (cfg_base),
            .d_cnt   (cfg_cnt),
            .d_unit  (cfg_unit),
            .d_rp    (cfg_rp),
            .d_wp    (cfg_wp),
            .locked  (locked),
            .q_addr  (req_addr),
            .q_write (req_write),
            .covers  (cover_vec[g]),
            .denies  (deny_vec[g])
        );
    end

    fg_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
        .deny_vec (deny_vec),
        .any      (deny_any),
        .idx      (deny_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_deny    <= 1'b0;
            rsp_rd_viol <= 1'b0;
            rsp_wr_viol <= 1'b0;
            rsp_idx     <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_deny    <= req_valid && deny_any;
            rsp_rd_viol <= req_valid && deny_any && !req_write;
            rsp_wr_viol <= req_valid && deny_any && req_write;
            rsp_idx     <= (req_valid && deny_any) ? deny_idx : '0;
        end
    end

    // R7: one response, one cycle after each request
    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_deny_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_deny |-> rsp_valid);

    // R5: never both violation kinds at once
    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_rd_viol, rsp_wr_viol}));

    // R8: a denial is only reported when some window covered the request
    p_deny_covered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cover_vec == '0)) |=> !rsp_deny);

endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int NE = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cfg_we = 0, cfg_unit = 0, cfg_rp = 0, cfg_wp = 0, cfg_lock = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic          req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_deny, rsp_rd_viol, rsp_wr_viol, cfg_err, locked;
    logic [IW-1:0] rsp_idx;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_cnt(cfg_cnt), .cfg_unit(cfg_unit),
        .cfg_rp(cfg_rp), .cfg_wp(cfg_wp), .cfg_lock(cfg_lock),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_deny(rsp_deny), .rsp_rd_viol(rsp_rd_viol),
        .rsp_wr_viol(rsp_wr_viol), .rsp_idx(rsp_idx), .cfg_err(cfg_err),
        .locked(locked)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    longint m_base [NE];
    int     m_cnt  [NE];
    bit     m_unit [NE], m_rp [NE], m_wp [NE];
    bit     m_lock, m_live;
    bit     e_valid, e_deny, e_rd, e_wr, e_err;
    int     e_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_base[e]) begin
                m_base[e] = 0; m_cnt[e] = 0; m_unit[e] = 0; m_rp[e] = 0; m_wp[e] = 0;
            end
            m_lock = 0; e_valid = 0; e_deny = 0; e_rd = 0; e_wr = 0; e_err = 0; e_idx = 0;
            m_live = 1;
        end else begin
            longint a;
            a = {32'h0, req_addr};
            e_deny = 0;
            e_idx  = 0;
            for (int e = NE - 1; e >= 0; e--) begin
                longint sz;
                bit cov;
                sz  = longint'(m_cnt[e]) << (m_unit[e] ? 16 : 12);
                cov = (m_cnt[e] != 0) && (a >= m_base[e]) && (a < m_base[e] + sz);
                if (cov && (req_write ? m_wp[e] : m_rp[e])) begin
                    e_deny = 1;
                    e_idx  = e;
                end
            end
            e_valid = req_valid;
            if (!req_valid) begin e_deny = 0; e_idx = 0; end
            e_rd  = e_deny && !req_write;
            e_wr  = e_deny && req_write;
            e_err = cfg_we && m_lock;
            if (cfg_we && !m_lock) begin
                m_base[cfg_idx] = {32'h0, cfg_base};
                m_cnt[cfg_idx]  = int'(cfg_cnt);
                m_unit[cfg_idx] = cfg_unit;
                m_rp[cfg_idx]   = cfg_rp;
                m_wp[cfg_idx]   = cfg_wp;
            end
            if (cfg_lock) m_lock = 1;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk(rsp_valid == e_valid, "R7", "rsp_valid", rsp_valid, e_valid);
            chk(rsp_deny == e_deny, "R5", "rsp_deny", rsp_deny, e_deny);
            chk(rsp_rd_viol == e_rd, "R5", "rsp_rd_viol", rsp_rd_viol, e_rd);
            chk(rsp_wr_viol == e_wr, "R5", "rsp_wr_viol", rsp_wr_viol, e_wr);
            chk(int'(rsp_idx) == e_idx, "R8", "rsp_idx", rsp_idx, e_idx);
            chk(cfg_err == e_err, "R10", "cfg_err", cfg_err, e_err);
            chk(locked == m_lock, "R9", "locked", locked, m_lock);
        end
    end

    task automatic put_cfg(input int idx, input logic [AW-1:0] b, input int c,
                           input bit u, input bit rp, input bit wp, input bit lk);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_base = b; cfg_cnt = CW'(c);
        cfg_unit = u; cfg_rp = rp; cfg_wp = wp; cfg_lock = lk;
        @(negedge clk);
        cfg_we = 0; cfg_lock = 0;
    endtask

    task automatic ask(input logic [AW-1:0] a, input bit wr, input bit x_deny,
                       input int x_idx, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_deny == x_deny, tag, "deny", rsp_deny, x_deny);
        if (x_deny) chk(int'(rsp_idx) == x_idx, tag, "idx", rsp_idx, x_idx);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
        chk(locked == 0, "R1", "locked", locked, 0);
        chk(cfg_err == 0, "R1", "cfg_err", cfg_err, 0);
        ask(32'hFFFFFFFF, 1, 0, 0, "R1");
        ask(32'h00000000, 0, 0, 0, "R1");

        put_cfg(0, 32'hFFF20000, 8'hDF, 0, 0, 1, 0);  // R2 window
        put_cfg(1, 32'hFF73A000, 8'h39, 1, 1, 1, 0);  // R3 window
        put_cfg(2, 32'h00000000, 0,     0, 1, 1, 0);  // R6 zero count
        put_cfg(3, 32'hFFF30000, 1,     1, 1, 0, 0);  // overlaps window 0

        // R2/R4: 0xDF * 4KB = 0xDF000, end 0xFFFFF000
        ask(32'hFFF20000, 1, 1, 0, "R4");
        ask(32'hFFF1FFFF, 1, 0, 0, "R4");
        ask(32'hFFFFEFFF, 1, 1, 0, "R2");
        ask(32'hFFFFF000, 1, 0, 0, "R2");
        // R3: 0x39 * 64KB = 0x390000, end 0xFFACA000
        ask(32'hFF73A000, 0, 1, 1, "R3");
        ask(32'hFFAC9FFF, 1, 1, 1, "R3");
        ask(32'hFFACA000, 1, 0, 0, "R3");
        // R5: window 0 is write-only protect
        ask(32'hFFF50000, 0, 0, 0, "R5");
        // R8: read in overlap skips window 0, write stops at window 0
        ask(32'hFFF30000, 0, 1, 3, "R8");
        ask(32'hFFF30000, 1, 1, 0, "R8");
        // R6: zero count at base 0
        ask(32'h00000000, 0, 0, 0, "R6");
        ask(32'h00000800, 1, 0, 0, "R6");

        // R12: write and request in the same cycle
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2; cfg_base = 32'hFFFF0000; cfg_cnt = 2;
        cfg_unit = 1; cfg_rp = 1; cfg_wp = 1;
        req_valid = 1; req_addr = 32'hFFFFFFFF; req_write = 0;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        chk(rsp_deny == 0, "R12", "old table", rsp_deny, 0);
        // R13: window runs past the top, no wrap
        ask(32'hFFFFFFFF, 0, 1, 2, "R13");
        ask(32'h00000000, 0, 0, 0, "R13");
        ask(32'h0000FFFF, 1, 0, 0, "R13");

        // R11: write and lock together
        put_cfg(3, 32'h00100000, 1, 1, 1, 1, 1);
        chk(locked == 1, "R9", "locked", locked, 1);
        ask(32'h00100000, 1, 1, 3, "R11");
        // R10: sealed write dropped, error pulse
        put_cfg(3, 32'h00000000, 0, 0, 0, 0, 0);
        chk(cfg_err == 1, "R10", "cfg_err pulse", cfg_err, 1);
        @(negedge clk);
        chk(cfg_err == 0, "R10", "cfg_err end", cfg_err, 0);
        ask(32'h00100000, 1, 1, 3, "R10");
        @(negedge clk);
        cfg_lock = 1;
        @(negedge clk);
        cfg_lock = 0;
        repeat (3) @(negedge clk);
        chk(locked == 1, "R9", "sticky", locked, 1);

        // R1: reset reopens and clears
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(locked == 0, "R1", "locked after reset", locked, 0);
        ask(32'h00100000, 1, 0, 0, "R1");
        ask(32'hFF73A000, 0, 0, 0, "R1");
        repeat (2) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule